// File: doc/BRIEF.md
# VGA raster timing generator

This block produces the horizontal and vertical synchronisation pulses for a 640 by 480 raster from a 25 MHz pixel clock, giving a refresh of close to 60 Hz. Two counters run without stopping. The column counter steps on every pixel clock. The row counter steps once each time a line finishes. Both wrap back to zero at the end of their span.

Each line has 800 clocks and each frame has 521 lines. The vertical back porch is 29 lines long, so the frame is shorter than the more common 525-line arrangement. A pixel source reads the column and row outputs and returns an 8-bit colour in the same cycle. The block forwards that colour to the display only inside the visible area and drives zero everywhere else. Every span length is a parameter, so a reduced raster can be built for fast checking.

Top module: `vga_raster_gen`

## Requirements
- R1: The column counter starts at 0 and counts up by one on every clock. After 799 it returns to 0, so a line lasts exactly 800 clocks.
- R2: Inside a line, columns 0 to 639 are visible. Columns 640 to 655 are the front porch. Columns 656 to 751 are the sync window, and `hsync_n` is 0 there and 1 on every other column. Columns 752 to 799 are the back porch.
- R3: The row counter changes only on the clock where the column counter wraps from 799 to 0. On that clock it steps by one. After row 520 it returns to 0, so a frame is 521 lines.
- R4: Rows 0 to 479 are visible. `vsync_n` is 0 on rows 490 and 491 and 1 on every other row.
- R5: `video_on` is 1 exactly when the column is below 640 and the row is below 480.
- R6: `rgb_out` equals `pix_in` while `video_on` is 1 and is all zeros otherwise. The layout is red in bits 7:5, green in bits 4:2 and blue in bits 1:0, and the bits pass through unchanged.
- R7: `col` and `row` carry the counter values while `video_on` is 1 and read 0 while it is 0.
- R8: A high `rst` at a clock edge clears both counters. While `rst` is held, and on the first cycle after it is released, the outputs show column 0 and row 0, with `video_on` at 1 and both sync outputs at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Colour for the current column and row (red 7:5, green 4:2, blue 1:0) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_on | output | 1 | High inside the visible area |
| col | output | 10 | Visible column, 0 outside the visible area |
| row | output | 10 | Visible row, 0 outside the visible area |
| rgb_out | output | 8 | Gated colour to the display |

## Verification
The two counters are the only registers in the block, and every output is decoded from them in the same cycle. After k clock edges since reset was released, the outputs therefore reflect column k mod 800 and row (k div 800) mod 521. `rgb_out` follows `pix_in` with no delay at all. The bench drives inputs and samples outputs at the falling edge, between rising edges. It compares each observation against the edge count since release, which it computes with its own modular arithmetic. A reduced-size copy of the block runs through many whole frames in the same way, so that vertical wrap and the vertical sync window are reached within a short run.

// File: rtl/vga_tim_pkg.sv
`timescale 1ns/1ps
package vga_tim_pkg;

  // Colour word: red in the top three bits, green in the middle three, blue in the bottom two
  typedef struct packed {
    logic [2:0] red;
    logic [2:0] grn;
    logic [1:0] blu;
  } rgb332_t;

  // True when v lies in the half-open span [lo, lo+len)
  function automatic logic in_span(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // Counter width needed to hold values 0 .. total-1
  function automatic int span_width(input int total);
    return (total <= 2) ? 1 : $clog2(total);
  endfunction

endpackage

// File: rtl/vga_span_counter.sv
`timescale 1ns/1ps
module vga_span_counter #(
  parameter int TOTAL = 800,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] count,
  output logic         at_end
);

  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign at_end = (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (adv)
      count <= at_end ? '0 : count + 1'b1;
  end

  // R1 / R3: an advance at the final value wraps back to zero
  p_span_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && at_end) |=> (count == '0));

  // R1 / R3: an advance below the final value steps by one
  p_span_step_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && !at_end) |=> (count == W'($past(count) + 1'b1)));

  // R3: with no advance the count holds
  p_span_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(count));

endmodule

// File: rtl/vga_axis_decode.sv
`timescale 1ns/1ps
module vga_axis_decode
  import vga_tim_pkg::*;
#(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int W    = 10
) (
  input  logic [W-1:0] count,
  output logic         visible,
  output logic         sync_n
);

  localparam int SYNC_LO = VIS + FP;

  always_comb begin
    visible = in_span(int'(count), 0, VIS);
    sync_n  = !in_span(int'(count), SYNC_LO, SYNC);
  end

endmodule

// File: rtl/vga_pixel_gate.sv
`timescale 1ns/1ps
module vga_pixel_gate
  import vga_tim_pkg::*;
#(
  parameter int CW = 10,
  parameter int RW = 10
) (
  input  logic          video_on,
  input  logic [CW-1:0] h_cnt,
  input  logic [RW-1:0] v_cnt,
  input  logic [7:0]    pix_in,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [7:0]    rgb_out
);

  rgb332_t pix_s;
  rgb332_t out_s;

  always_comb begin
    pix_s = rgb332_t'(pix_in);
    out_s = video_on ? pix_s : '0;
    col   = video_on ? h_cnt : '0;
    row   = video_on ? v_cnt : '0;
  end

  assign rgb_out = out_s;

endmodule

// File: rtl/vga_raster_gen.sv
`timescale 1ns/1ps
module vga_raster_gen
  import vga_tim_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 29,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int CW      = span_width(H_TOTAL),
  localparam int RW      = span_width(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    pix_in,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          video_on,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [7:0]    rgb_out
);

  logic [CW-1:0] h_cnt;
  logic [RW-1:0] v_cnt;
  logic          h_end;
  logic          v_end;
  logic          h_vis;
  logic          v_vis;
  logic          v_sync_n;
  logic          h_sync_n;

  // Column counter: advances every pixel clock
  vga_span_counter #(.TOTAL(H_TOTAL), .W(CW)) u_hcnt (
    .clk   (clk),
    .rst   (rst),
    .adv   (1'b1),
    .count (h_cnt),
    .at_end(h_end)
  );

  // Row counter: advances when a line completes
  vga_span_counter #(.TOTAL(V_TOTAL), .W(RW)) u_vcnt (
    .clk   (clk),
    .rst   (rst),
    .adv   (h_end),
    .count (v_cnt),
    .at_end(v_end)
  );

  vga_axis_decode #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .W(CW)) u_hdec (
    .count  (h_cnt),
    .visible(h_vis),
    .sync_n (h_sync_n)
  );

  vga_axis_decode #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .W(RW)) u_vdec (
    .count  (v_cnt),
    .visible(v_vis),
    .sync_n (v_sync_n)
  );

  assign video_on = h_vis && v_vis;
  assign hsync_n  = h_sync_n;
  assign vsync_n  = v_sync_n;

  vga_pixel_gate #(.CW(CW), .RW(RW)) u_gate (
    .video_on(video_on),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .pix_in  (pix_in),
    .col     (col),
    .row     (row),
    .rgb_out (rgb_out)
  );

  // R2: the horizontal sync pulse begins right after the front porch
  p_hs_start_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (h_cnt == CW'(H_VIS + H_FP)));

  // R3: the row changes only on the cycle after a line end
  p_row_moves_on_line_end_r3: assert property (@(posedge clk) disable iff (rst)
    !h_end |=> $stable(v_cnt));

  // R3: the whole frame wraps together after the last clock of the last line
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (h_end && v_end) |=> (v_cnt == '0 && h_cnt == '0));

  // R5: no sync pulse ever overlaps visible video
  p_sync_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> !video_on);

  // R6 / R7: outside the visible area colour and coordinates are zero
  p_blank_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !video_on |-> (rgb_out == 8'h00 && col == '0 && row == '0));

  // R6: inside the visible area colour passes through unchanged
  p_colour_pass_r6: assert property (@(posedge clk) disable iff (rst)
    video_on |-> (rgb_out == pix_in));

endmodule

// File: tb/vga_raster_gen_bench.sv
`timescale 1ns/1ps
module vga_raster_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Full-size instance
  logic [7:0] pix_a = 8'hA5;
  logic       hs_a, vs_a, von_a;
  logic [9:0] col_a, row_a;
  logic [7:0] rgb_a;

  vga_raster_gen u_vga_raster_gen (
    .clk(clk), .rst(rst), .pix_in(pix_a),
    .hsync_n(hs_a), .vsync_n(vs_a), .video_on(von_a),
    .col(col_a), .row(row_a), .rgb_out(rgb_a)
  );

  // Reduced raster: line of 15 (8 vis, 2 fp, 3 sync, 2 bp), frame of 12 (6 vis, 1 fp, 2 sync, 3 bp)
  logic [7:0] pix_b = 8'h00;
  logic       hs_b, vs_b, von_b;
  logic [3:0] col_b, row_b;
  logic [7:0] rgb_b;

  vga_raster_gen #(
    .H_VIS(8), .H_FP(2), .H_SYNC(3), .H_BP(2),
    .V_VIS(6), .V_FP(1), .V_SYNC(2), .V_BP(3)
  ) u_small (
    .clk(clk), .rst(rst), .pix_in(pix_b),
    .hsync_n(hs_b), .vsync_n(vs_b), .video_on(von_b),
    .col(col_b), .row(row_b), .rgb_out(rgb_b)
  );

  typedef struct packed {
    int cyc;
    int hs;
    int von;
    int col;
    int row;
  } vec_t;

  // Full-size vectors: clock edges since release, expected hsync_n, video_on, col, row
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{0,    1, 1, 0,   0},
    '{1,    1, 1, 1,   0},
    '{639,  1, 1, 639, 0},
    '{640,  1, 0, 0,   0},
    '{655,  1, 0, 0,   0},
    '{656,  0, 0, 0,   0},
    '{751,  0, 0, 0,   0},
    '{752,  1, 0, 0,   0},
    '{799,  1, 0, 0,   0},
    '{800,  1, 1, 0,   1},
    '{801,  1, 1, 1,   1},
    '{1456, 0, 0, 0,   0},
    '{2405, 1, 1, 5,   3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model of the reduced raster, from edge count since release
  task automatic check_small(input int n);
    int h, v, hs, vs, on;
    h  = n % 15;
    v  = (n / 15) % 12;
    hs = (h == 10 || h == 11 || h == 12) ? 0 : 1;
    vs = (v == 7 || v == 8) ? 0 : 1;
    on = (h < 8 && v < 6) ? 1 : 0;
    chk("R2 small hsync_n", int'(hs_b), hs);
    chk("R4 small vsync_n", int'(vs_b), vs);
    chk("R5 small video_on", int'(von_b), on);
    chk("R7 small col", int'(col_b), on ? h : 0);
    chk("R3 small row", int'(row_b), on ? v : 0);
    chk("R6 small rgb", int'(rgb_b), on ? int'(pix_b) : 0);
  endtask

  initial begin
    int vi;
    vi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #0.5;
    // R8: state while reset is held
    chk("R8 reset col", int'(col_a), 0);
    chk("R8 reset row", int'(row_a), 0);
    chk("R8 reset video_on", int'(von_a), 1);
    chk("R8 reset hsync_n", int'(hs_a), 1);
    chk("R8 reset vsync_n", int'(vs_a), 1);
    chk("R6 reset rgb", int'(rgb_a), 8'hA5);
    rst = 1'b0;
    for (int n = 0; n <= 2405; n++) begin
      pix_b = 8'((n * 37) + 11);
      #0.5;
      check_small(n);
      if (vi < NVEC && VEC[vi].cyc == n) begin
        chk("R2 hsync_n", int'(hs_a), VEC[vi].hs);
        chk("R5 video_on", int'(von_a), VEC[vi].von);
        chk("R1 col", int'(col_a), VEC[vi].col);
        chk("R3 row", int'(row_a), VEC[vi].row);
        chk("R4 vsync_n", int'(vs_a), 1);
        chk("R6 rgb", int'(rgb_a), VEC[vi].von ? 8'hA5 : 0);
        vi++;
      end
      @(negedge clk);
    end
    // R8: reset applied mid-line clears both counters
    rst = 1'b1;
    @(negedge clk);
    #0.5;
    chk("R8 mid reset col", int'(col_a), 0);
    chk("R8 mid reset row", int'(row_a), 0);
    chk("R8 mid reset video_on", int'(von_a), 1);
    chk("R8 mid reset small col", int'(col_b), 0);
    chk("R8 mid reset small row", int'(row_b), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    #0.5;
    chk("R8 restart col", int'(col_a), 5);
    chk("R8 restart row", int'(row_a), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule